// File: doc/BRIEF.md
# Serial PCM Audio DAC Transmitter

This block takes stereo PCM sample pairs in parallel form and sends them one bit at a time to an external audio DAC. It runs on the master audio clock and produces four outputs for the converter: a sample clock at half the master rate, a bit clock whose period is a programmable number of master cycles, a left/right channel clock, and the serial data line.

Each frame has two slots of 32 bit clocks each, left first and then right. A sample sits at the tail of its slot, most significant bit first. Every slot position ahead of the sample repeats the sample's sign bit. The precision setting selects 20 or 24 significant bits. A polarity setting chooses which channel-clock level marks the left slot.

The block pulses a request once per frame. The source may then present a new pair with a valid strobe. The block holds the most recently accepted pair and sends it in every frame that starts after it was accepted. If no new pair arrives, the previous pair is sent again.

Top module: `pcmtx_top`

## Requirements
- R1: The bit clock period equals `div_ratio_i` master cycles. Any ratio below 2 is used as 2. Each period is high for the larger half of its cycles and starts with its falling edge.
- R2: A frame is exactly 64 bit-clock periods long. `pair_req_o` is high for one master cycle on the edge where the bit clock falls for the first bit of each frame.
- R3: With `prec_i` = 0 (20-bit), each slot sends 12 copies of bit 19 and then bits 19 down to 0. Bits 23..20 of the input are ignored.
- R4: With `prec_i` = 1 (24-bit), each slot sends 8 copies of bit 23 and then bits 23 down to 0.
- R5: The padding bits are 1 for a negative sample and 0 for a non-negative sample, so they always equal the sample's top significant bit.
- R6: The channel clock is at level `lr_inv_i` for the whole left slot and at the opposite level for the whole right slot. It changes once per slot.
- R7: Serial data and the channel clock change only on the master edge where the bit clock falls. They are therefore stable while the bit clock is high.
- R8: A pair presented with `pair_valid_i` is sent from the next frame start onward. It is repeated in every later frame until a new pair is accepted.
- R9: Changes to `prec_i` and `lr_inv_i` made during a frame take effect at the next frame start and not earlier.
- R10: While `rst` is high, the data line is 0, the bit clock is high, the request is low and the channel clock sits at the left level set by `lr_inv_i`. The first frame after reset sends zero samples unless a pair has already been accepted.
- R11: `dac_sclk_o` toggles on every master cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst | input | 1 | Synchronous active-high reset |
| div_ratio_i | input | 8 | Master cycles per bit clock |
| prec_i | input | 1 | Sample precision: 0 = 20 bit, 1 = 24 bit |
| lr_inv_i | input | 1 | Channel clock level that marks the left slot |
| pair_valid_i | input | 1 | Strobe that accepts `left_i`/`right_i` |
| left_i | input | 24 | Left PCM sample, two's complement |
| right_i | input | 24 | Right PCM sample, two's complement |
| pair_req_o | output | 1 | One-cycle pulse at each frame start |
| dac_sclk_o | output | 1 | Sample clock to the DAC (master / 2) |
| dac_bclk_o | output | 1 | Bit clock |
| dac_lrclk_o | output | 1 | Left/right channel clock |
| dac_sdata_o | output | 1 | Serial sample data |

## Verification
The hardest case to reach from the ports is a precision or polarity change that lands in the middle of a frame. The frame already on the wire must keep its old format, and the very next frame must switch completely. The stimulus changes these settings after a random delay inside each frame and sometimes skips supplying a new pair. A bench model records the setting and pair in force at each request pulse and rebuilds both expected slot words from them. Directed pairs at both sign extremes, and 20-bit pairs with non-zero upper bits, cover the padding rules.

// File: rtl/pcmtx_pkg.sv
package pcmtx_pkg;

    localparam int SLOT_BITS  = 32;
    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam int SAMPLE_W   = 24;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int IDX_W      = $clog2(SLOT_BITS);

    typedef enum logic {
        PREC_20 = 1'b0,
        PREC_24 = 1'b1
    } prec_e;

    typedef struct packed {
        prec_e prec;
        logic  lr_inv;
    } fmt_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } pair_t;

    function automatic int prec_bits(input prec_e p);
        return (p == PREC_24) ? 24 : 20;
    endfunction

    // Bit sent at slot index idx (0 = first bit of the slot)
    function automatic logic slot_bit(input logic [SAMPLE_W-1:0] s,
                                      input prec_e p,
                                      input logic [IDX_W-1:0] idx);
        int b;
        int w;
        b = SLOT_BITS - 1 - int'(idx);
        w = prec_bits(p);
        if (b >= w) return s[w-1];
        return s[b];
    endfunction

endpackage

// File: rtl/pcmtx_bitclk.sv
module pcmtx_bitclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] ratio_i,
    output logic             bclk_o,
    output logic             fall_stb_o
);
    localparam logic [DIV_W-1:0] MIN_RATIO = DIV_W'(2);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] ratio_q;
    logic [DIV_W-1:0] ratio_eff;
    logic [DIV_W-1:0] half;
    logic             bclk_q;

    assign ratio_eff  = (ratio_i < MIN_RATIO) ? MIN_RATIO : ratio_i;
    assign half       = ratio_q >> 1;
    assign fall_stb_o = (cnt_q == ratio_q - DIV_W'(1));
    assign bclk_o     = bclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            bclk_q  <= 1'b1;
            ratio_q <= ratio_eff;
        end else if (fall_stb_o) begin
            cnt_q   <= '0;
            bclk_q  <= 1'b0;
            ratio_q <= ratio_eff;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
            if (cnt_q == half - DIV_W'(1)) bclk_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pcmtx_framer.sv
module pcmtx_framer
    import pcmtx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fall_stb_i,
    input  fmt_t             fmt_i,
    output logic [POS_W-1:0] pos_nxt_o,
    output logic             frame_start_o,
    output fmt_t             fmt_cur_o,
    output logic             lrclk_o,
    output logic             req_o
);
    logic             run_q;
    logic [POS_W-1:0] pos_q;
    fmt_t             fmt_q;
    logic             lr_q;
    logic             req_q;
    logic             slot_right;

    always_comb begin
        if (!run_q)
            pos_nxt_o = '0;
        else if (pos_q == POS_W'(FRAME_BITS - 1))
            pos_nxt_o = '0;
        else
            pos_nxt_o = pos_q + POS_W'(1);
    end

    assign frame_start_o = fall_stb_i && (pos_nxt_o == '0);
    assign fmt_cur_o     = frame_start_o ? fmt_i : fmt_q;
    assign slot_right    = pos_nxt_o[POS_W-1];
    assign lrclk_o       = lr_q;
    assign req_o         = req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            pos_q <= '0;
            fmt_q <= fmt_i;
            lr_q  <= fmt_i.lr_inv;
            req_q <= 1'b0;
        end else begin
            req_q <= frame_start_o;
            if (fall_stb_i) begin
                run_q <= 1'b1;
                pos_q <= pos_nxt_o;
                lr_q  <= slot_right ^ fmt_cur_o.lr_inv;
                if (frame_start_o) fmt_q <= fmt_i;
            end
        end
    end
endmodule

// File: rtl/pcmtx_serializer.sv
module pcmtx_serializer
    import pcmtx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fall_stb_i,
    input  logic             frame_start_i,
    input  logic [POS_W-1:0] pos_i,
    input  fmt_t             fmt_i,
    input  logic             valid_i,
    input  pair_t            pair_i,
    output logic             sdata_o
);
    pair_t               pend_q;
    pair_t               hold_q;
    pair_t               hold_cur;
    logic [SAMPLE_W-1:0] sample;
    logic                sdata_q;

    assign hold_cur = frame_start_i ? pend_q : hold_q;
    assign sample   = pos_i[POS_W-1] ? hold_cur.right : hold_cur.left;
    assign sdata_o  = sdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            hold_q  <= '0;
            sdata_q <= 1'b0;
        end else begin
            if (valid_i) pend_q <= pair_i;
            if (frame_start_i) hold_q <= pend_q;
            if (fall_stb_i)
                sdata_q <= slot_bit(sample, fmt_i.prec, pos_i[IDX_W-1:0]);
        end
    end
endmodule

// File: rtl/pcmtx_top.sv
module pcmtx_top
    import pcmtx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DIV_W-1:0]    div_ratio_i,
    input  logic                prec_i,
    input  logic                lr_inv_i,
    input  logic                pair_valid_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic                pair_req_o,
    output logic                dac_sclk_o,
    output logic                dac_bclk_o,
    output logic                dac_lrclk_o,
    output logic                dac_sdata_o
);
    logic             fall_stb;
    logic             frame_start;
    logic [POS_W-1:0] pos_nxt;
    fmt_t             fmt_in;
    fmt_t             fmt_cur;
    pair_t            pair_in;
    logic             sclk_q;

    assign fmt_in.prec   = prec_e'(prec_i);
    assign fmt_in.lr_inv = lr_inv_i;
    assign pair_in.left  = left_i;
    assign pair_in.right = right_i;

    pcmtx_bitclk #(.DIV_W(DIV_W)) u_bitclk (
        .clk        (clk),
        .rst        (rst),
        .ratio_i    (div_ratio_i),
        .bclk_o     (dac_bclk_o),
        .fall_stb_o (fall_stb)
    );

    pcmtx_framer u_framer (
        .clk           (clk),
        .rst           (rst),
        .fall_stb_i    (fall_stb),
        .fmt_i         (fmt_in),
        .pos_nxt_o     (pos_nxt),
        .frame_start_o (frame_start),
        .fmt_cur_o     (fmt_cur),
        .lrclk_o       (dac_lrclk_o),
        .req_o         (pair_req_o)
    );

    pcmtx_serializer u_ser (
        .clk           (clk),
        .rst           (rst),
        .fall_stb_i    (fall_stb),
        .frame_start_i (frame_start),
        .pos_i         (pos_nxt),
        .fmt_i         (fmt_cur),
        .valid_i       (pair_valid_i),
        .pair_i        (pair_in),
        .sdata_o       (dac_sdata_o)
    );

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= ~sclk_q;
    end
    assign dac_sclk_o = sclk_q;

endmodule

// File: rtl/pcmtx_checker.sv
module pcmtx_checker (
    input logic clk,
    input logic rst,
    input logic bclk,
    input logic lrclk,
    input logic sdata,
    input logic req,
    input logic sclk
);
    // R7: data moves only with a falling bit clock
    a_r7_data_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdata) |-> $fell(bclk));

    // R7: channel clock moves only with a falling bit clock
    a_r7_lr_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(lrclk) |-> $fell(bclk));

    // R2: request is a single-cycle pulse
    a_r2_req_single: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);

    // R2: request coincides with a bit-clock fall
    a_r2_req_on_fall: assert property (@(posedge clk) disable iff (rst)
        req |-> $fell(bclk));

    // R11: sample clock toggles every cycle
    a_r11_sclk_toggle: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sclk != $past(sclk)));

    // R10: reset state of the outputs
    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (!sdata && bclk && !req));
endmodule

bind pcmtx_top pcmtx_checker i_chk (
    .clk   (clk),
    .rst   (rst),
    .bclk  (dac_bclk_o),
    .lrclk (dac_lrclk_o),
    .sdata (dac_sdata_o),
    .req   (pair_req_o),
    .sclk  (dac_sclk_o)
);

// File: tb/test_pcmtx_top.sv
module test_pcmtx_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  div_ratio = 8'd2;
    logic        prec = 1'b1;
    logic        lr_inv = 1'b0;
    logic        pvalid = 1'b0;
    logic [23:0] left_s = '0;
    logic [23:0] right_s = '0;
    logic        req, sclk, bclk, lrclk, sdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pcmtx_top i_pcmtx_top (
        .clk(clk), .rst(rst), .div_ratio_i(div_ratio), .prec_i(prec),
        .lr_inv_i(lr_inv), .pair_valid_i(pvalid), .left_i(left_s),
        .right_i(right_s), .pair_req_o(req), .dac_sclk_o(sclk),
        .dac_bclk_o(bclk), .dac_lrclk_o(lrclk), .dac_sdata_o(sdata)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [23:0] s, input bit p24);
        int w;
        logic [31:0] r;
        w = p24 ? 24 : 20;
        for (int b = 0; b < 32; b++) r[b] = (b < w) ? s[b] : s[w-1];
        return r;
    endfunction

    // model state written by the stimulus
    logic [23:0] m_left = '0, m_right = '0;

    // monitor state
    int          cyc = 0, last_rise = -1, last_period = 0, nb = 0;
    bit          have = 0, lr_bad = 0, edge_bad = 0, sclk_bad = 0;
    logic        p_bclk = 1, p_sdata = 0, p_lr = 0, p_sclk = 0;
    logic [31:0] lw, rw;
    logic [23:0] rec_l, rec_r;
    bit          rec_p24, rec_inv;
    int          eff_ratio;

    always @(negedge clk) begin
        if (rst) begin
            have = 0; nb = 0; last_rise = -1; last_period = 0;
            lr_bad = 0; edge_bad = 0; sclk_bad = 0;
        end else begin
            cyc++;
            if (bclk && !p_bclk) begin
                if (last_rise >= 0) last_period = cyc - last_rise;
                last_rise = cyc;
                if (have && nb < 64) begin
                    if (nb < 32) begin
                        lw = {lw[30:0], sdata};
                        if (lrclk != rec_inv) lr_bad = 1;
                    end else begin
                        rw = {rw[30:0], sdata};
                        if (lrclk != !rec_inv) lr_bad = 1;
                    end
                    nb++;
                end
            end
            if ((sdata != p_sdata || lrclk != p_lr) && !(p_bclk && !bclk)) edge_bad = 1;
            if (sclk == p_sclk) sclk_bad = 1;
            if (req) begin
                if (have) begin
                    check(nb == 64, "R2 bits per frame", nb, 64);
                    check(last_period == eff_ratio, "R1 bit clock period",
                          last_period, eff_ratio);
                    check(lw == exp_word(rec_l, rec_p24),
                          rec_p24 ? "R4 R5 R8 R9 left slot" : "R3 R5 R8 R9 left slot",
                          lw, exp_word(rec_l, rec_p24));
                    check(rw == exp_word(rec_r, rec_p24),
                          rec_p24 ? "R4 R5 R8 R9 right slot" : "R3 R5 R8 R9 right slot",
                          rw, exp_word(rec_r, rec_p24));
                    check(!lr_bad, "R6 R9 channel clock level", lr_bad, 0);
                    check(!edge_bad, "R7 changes only at bclk fall", edge_bad, 0);
                    check(!sclk_bad, "R11 sample clock toggle", sclk_bad, 0);
                end
                rec_l = m_left; rec_r = m_right;
                rec_p24 = prec; rec_inv = lr_inv;
                have = 1; nb = 0; lr_bad = 0; edge_bad = 0; sclk_bad = 0;
            end
        end
        p_bclk = bclk; p_sdata = sdata; p_lr = lrclk; p_sclk = sclk;
    end

    task automatic run(input logic [7:0] ratio, input int frames);
        rst = 1'b1;
        div_ratio = ratio;
        eff_ratio = (ratio < 2) ? 2 : int'(ratio);
        prec = 1'($urandom_range(0, 1));
        lr_inv = 1'($urandom_range(0, 1));
        m_left = '0; m_right = '0; pvalid = 1'b0;
        repeat (3) @(negedge clk);
        check(sdata == 1'b0 && bclk == 1'b1 && req == 1'b0 && lrclk == lr_inv,
              "R10 reset state", {sdata, bclk, req, lrclk},
              {1'b0, 1'b1, 1'b0, lr_inv});
        @(posedge clk); #1 rst = 1'b0;
        for (int f = 0; f < frames; f++) begin
            do @(negedge clk); while (!req);
            @(posedge clk); #1;
            if (f < 3 || $urandom_range(0, 1) == 1) begin
                case (f)
                    0: begin left_s = 24'h800000; right_s = 24'h7FFFFF; end
                    1: begin left_s = 24'hF80001; right_s = 24'hA7FFFF; end
                    2: begin left_s = 24'h000001; right_s = 24'hFFFFFF; end
                    default: begin
                        left_s = 24'($urandom); right_s = 24'($urandom);
                    end
                endcase
                pvalid = 1'b1; m_left = left_s; m_right = right_s;
                @(posedge clk); #1 pvalid = 1'b0;
            end
            if ($urandom_range(0, 2) != 0) begin
                repeat ($urandom_range(1, 32 * eff_ratio)) @(posedge clk);
                #1;
                prec = 1'($urandom_range(0, 1));
                lr_inv = 1'($urandom_range(0, 1));
            end
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        run(8'd2, 14);
        run(8'd5, 10);
        run(8'd0, 10);   // clamp to 2 (R1)
        run(8'd3, 12);
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule